// File: doc/BRIEF.md
# Staged Reset Sequencer with Register Access Gating

This block brings a chip out of reset in a fixed order and keeps the host register bus from touching anything that is not yet safe. Either a power-on indication or a low level on the external reset pin puts every internal domain into reset. While that reset is held, the block samples the configuration strap pins. After release it passes through three stages. The first is a short serial-interface stage, after which the identity word becomes readable. The second is a long base delay. The third starts the configuration loader and waits for it to report completion. Only then does it raise the ready flag.

The host side is a simple single-cycle request bus. While the ready flag is low, only the identity word, the system configuration word and the reset control word may be read. Every other read is refused, and every write is dropped. A refused access returns zero and raises an error flag for one cycle. Once ready, a write to the reset control word can restart the whole sequence.

The state machine has six states:
- `ST_HOLD`: reset held, straps sampled.
- `ST_SIF`: serial-interface stage.
- `ST_BASE`: base delay.
- `ST_KICK`: loader start pulse.
- `ST_LWAIT`: waiting for the loader.
- `ST_RUN`: ready.

Its transitions are:
- HOLD→SIF when the synchronized pin is high.
- SIF→BASE after `SIF_CYCLES` cycles.
- BASE→KICK after `BASE_CYCLES` cycles.
- KICK→LWAIT unconditionally.
- LWAIT→RUN on `ldr_done`.
- Any state→HOLD on a synchronized pin low or a software restart.

Top module: `chip_reset_gate`

## Requirements
- R1: While `por_n` is low, or two cycles after `ext_rst_n` is seen low, the block is in `ST_HOLD`: `dom_rst_n`=0, `ready`=0, `ldr_start`=0. This applies in any state, and after release the sequence restarts from the first stage.
- R2: `ext_rst_n` passes through a two-flop synchronizer. `ldr_start` rises exactly 3+`SIF_CYCLES`+`BASE_CYCLES` clock edges after the pin goes high, and stays high for one cycle only.
- R3: `strap_in` is captured on every cycle spent in `ST_HOLD`. Address 1 (system configuration) reads the last captured value in bits [8 +: STRAP_W] and `ready` in bit 0. All other bits read zero.
- R4: Address 0 (identity word) reads 32'hFFFFFFFF while in `ST_HOLD` or `ST_SIF`, and reads 32'h87654321 in all later states. This read is never refused.
- R5: `ready` rises one cycle after `ldr_done` is high in `ST_LWAIT`. `ldr_done` in any other state has no effect.
- R6: While `ready`=0, a read of addresses 0, 1 or 2 is accepted (`rsp_err`=0). A read of any other address returns 0 with `rsp_err`=1.
- R7: While `ready`=0, every write is ignored and answered with `rsp_err`=1.
- R8: Every request (`bus_req`=1) is answered on the next clock edge: `rsp_valid`=1 with `rsp_rdata`/`rsp_err`. A write answer carries data 0. Without a request, `rsp_valid`=0.
- R9: Address 2 (reset control) reads 0. A write with bit 0 = 1 while ready moves the block to `ST_HOLD` on the same edge, so `ldr_start` follows 1+`SIF_CYCLES`+`BASE_CYCLES` edges later.
- R10: Address 3 is a 32-bit scratch word, writable only when ready and cleared while `dom_rst_n`=0. Addresses 4 to 15 always read 0 with `rsp_err`=1, and writes to them get `rsp_err`=1.
- R11: When ready, writes to addresses 0 and 1 are accepted (`rsp_err`=0) and leave their contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| strap_in | input | STRAP_W | Configuration strap pins |
| ldr_done | input | 1 | Loader completion pulse |
| bus_req | input | 1 | Host access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| dom_rst_n | output | 1 | Reset to all internal domains, active low |
| ldr_start | output | 1 | One-cycle loader start pulse |
| ready | output | 1 | Device accessible |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Response data |
| rsp_err | output | 1 | Access refused |

## Verification
Each bus response is registered and is due at the first clock edge after the request, so the bench drives a request at a falling edge and samples the response at the next falling edge. The loader start is due a fixed 3+SIF+BASE edges after the pin is released, or 1+SIF+BASE edges after a software restart. The bench counts edges at falling-edge samples and compares the count with that figure. The ready flag is due one edge after the done pulse and is sampled at the falling edge that follows.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_SIF,
        ST_BASE,
        ST_KICK,
        ST_LWAIT,
        ST_RUN
    } seq_state_t;

    localparam logic [DATA_W-1:0] ID_PATTERN = 32'h8765_4321;
    localparam logic [DATA_W-1:0] ID_INVALID = 32'hFFFF_FFFF;

    localparam int ADR_ID      = 0;
    localparam int ADR_SYSCFG  = 1;
    localparam int ADR_RSTCTL  = 2;
    localparam int ADR_SCRATCH = 3;
    localparam int ADR_LAST    = ADR_SCRATCH;
    localparam int ADR_WL_LAST = ADR_RSTCTL;
endpackage

// File: rtl/rsg_pin_sync.sv
module rsg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic pin_n_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_n};
        end
    end

    assign pin_n_sync = chain[STAGES-1];
endmodule

// File: rtl/rsg_sequencer.sv
module rsg_sequencer
    import rsg_pkg::*;
#(
    parameter int SIF_CYCLES  = 64,
    parameter int BASE_CYCLES = 2875000
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n_sync,
    input  logic soft_rst,
    input  logic ldr_done,
    output logic dom_rst_n,
    output logic id_valid,
    output logic strap_capture,
    output logic ldr_start,
    output logic ready
);
    localparam int MAX_CYC = (SIF_CYCLES > BASE_CYCLES) ? SIF_CYCLES : BASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SIF_LAST  = CNT_W'(SIF_CYCLES - 1);
    localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE_CYCLES - 1);

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             counting;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!pin_n_sync || soft_rst) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD:  state_nx = ST_SIF;
                ST_SIF:   if (cnt == SIF_LAST)  state_nx = ST_BASE;
                ST_BASE:  if (cnt == BASE_LAST) state_nx = ST_KICK;
                ST_KICK:  state_nx = ST_LWAIT;
                ST_LWAIT: if (ldr_done) state_nx = ST_RUN;
                ST_RUN:   state_nx = ST_RUN;
                default:  state_nx = ST_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    // stage timer, cleared on every state change
    assign counting = (state == ST_SIF) || (state == ST_BASE);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (state_nx != state) begin
            cnt <= '0;
        end else if (counting) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs, Moore style
    always_comb begin
        dom_rst_n     = 1'b1;
        id_valid      = 1'b1;
        strap_capture = 1'b0;
        ldr_start     = 1'b0;
        ready         = 1'b0;
        unique case (state)
            ST_HOLD: begin
                dom_rst_n     = 1'b0;
                id_valid      = 1'b0;
                strap_capture = 1'b1;
            end
            ST_SIF: begin
                dom_rst_n = 1'b0;
                id_valid  = 1'b0;
            end
            ST_BASE:  ;
            ST_KICK:  ldr_start = 1'b1;
            ST_LWAIT: ;
            ST_RUN:   ready = 1'b1;
            default: begin
                dom_rst_n = 1'b0;
                id_valid  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rsg_regbus.sv
module rsg_regbus
    import rsg_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int STRAP_W = 8
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ready,
    input  logic               id_valid,
    input  logic               dom_rst_n,
    input  logic               strap_capture,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               soft_rst,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err
);
    localparam int STRAP_LSB = 8;

    logic [STRAP_W-1:0] strap_q;
    logic [DATA_W-1:0]  scratch_q;
    logic               decoded;
    logic               whitelisted;
    logic               refuse;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  syscfg_word;

    assign decoded     = (int'(bus_addr) <= ADR_LAST);
    assign whitelisted = (int'(bus_addr) <= ADR_WL_LAST);

    always_comb begin
        syscfg_word = '0;
        syscfg_word[STRAP_LSB +: STRAP_W] = strap_q;
        syscfg_word[0] = ready;
    end

    always_comb begin
        rd_word = '0;
        if (decoded) begin
            unique case (int'(bus_addr))
                ADR_ID:      rd_word = id_valid ? ID_PATTERN : ID_INVALID;
                ADR_SYSCFG:  rd_word = syscfg_word;
                ADR_RSTCTL:  rd_word = '0;
                ADR_SCRATCH: rd_word = scratch_q;
                default:     rd_word = '0;
            endcase
        end
    end

    always_comb begin
        if (bus_we) begin
            refuse = !ready || !decoded;
        end else begin
            refuse = !decoded || (!ready && !whitelisted);
        end
    end

    assign soft_rst = bus_req && bus_we && ready &&
                      (int'(bus_addr) == ADR_RSTCTL) && bus_wdata[0];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            strap_q <= '0;
        end else if (strap_capture) begin
            strap_q <= strap_in;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            scratch_q <= '0;
        end else if (!dom_rst_n) begin
            scratch_q <= '0;
        end else if (bus_req && bus_we && ready &&
                     (int'(bus_addr) == ADR_SCRATCH)) begin
            scratch_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= bus_req;
            if (bus_req) begin
                rsp_err   <= refuse;
                rsp_rdata <= (bus_we || refuse) ? '0 : rd_word;
            end else begin
                rsp_err   <= 1'b0;
                rsp_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/chip_reset_gate.sv
module chip_reset_gate
    import rsg_pkg::*;
#(
    parameter int SIF_CYCLES  = 64,
    parameter int BASE_CYCLES = 2875000,
    parameter int STRAP_W     = 8,
    parameter int ADDR_W      = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               ldr_done,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               dom_rst_n,
    output logic               ldr_start,
    output logic               ready,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_err
);
    logic pin_n_sync;
    logic soft_rst;
    logic id_valid;
    logic strap_capture;

    rsg_pin_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .por_n      (por_n),
        .pin_n      (ext_rst_n),
        .pin_n_sync (pin_n_sync)
    );

    rsg_sequencer #(
        .SIF_CYCLES  (SIF_CYCLES),
        .BASE_CYCLES (BASE_CYCLES)
    ) u_seq (
        .clk           (clk),
        .por_n         (por_n),
        .pin_n_sync    (pin_n_sync),
        .soft_rst      (soft_rst),
        .ldr_done      (ldr_done),
        .dom_rst_n     (dom_rst_n),
        .id_valid      (id_valid),
        .strap_capture (strap_capture),
        .ldr_start     (ldr_start),
        .ready         (ready)
    );

    rsg_regbus #(
        .ADDR_W  (ADDR_W),
        .STRAP_W (STRAP_W)
    ) u_bus (
        .clk           (clk),
        .por_n         (por_n),
        .ready         (ready),
        .id_valid      (id_valid),
        .dom_rst_n     (dom_rst_n),
        .strap_capture (strap_capture),
        .strap_in      (strap_in),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .soft_rst      (soft_rst),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_err       (rsp_err)
    );
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              dom_rst_n,
    input logic              ldr_start,
    input logic              ldr_done,
    input logic              ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err
);
    a_r1_reset_blocks_ready: assert property (@(posedge clk) disable iff (!por_n)
        !dom_rst_n |-> !ready);

    a_r2_start_single_cycle: assert property (@(posedge clk) disable iff (!por_n)
        ldr_start |=> !ldr_start);

    a_r5_ready_needs_done: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ready) |-> $past(ldr_done));

    a_r6_refused_read: assert property (@(posedge clk) disable iff (!por_n)
        (bus_req && !bus_we && !ready && (int'(bus_addr) > 2))
        |=> (rsp_err && rsp_rdata == 32'd0));

    a_r7_write_blocked: assert property (@(posedge clk) disable iff (!por_n)
        (bus_req && bus_we && !ready) |=> rsp_err);

    a_r8_response_due: assert property (@(posedge clk) disable iff (!por_n)
        bus_req |=> rsp_valid);

    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!por_n)
        !bus_req |=> !rsp_valid);
endmodule

bind chip_reset_gate rsg_checker #(.ADDR_W(ADDR_W)) u_rsg_checker (
    .clk       (clk),
    .por_n     (por_n),
    .dom_rst_n (dom_rst_n),
    .ldr_start (ldr_start),
    .ldr_done  (ldr_done),
    .ready     (ready),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/tb_chip_reset_gate.sv
`timescale 1ns/1ps
module tb_chip_reset_gate;
    localparam int SIF  = 4;
    localparam int BASE = 20;
    localparam int SW   = 8;
    localparam int AW   = 4;
    localparam int PIN_TO_START  = 3 + SIF + BASE;
    localparam int SOFT_TO_START = 1 + SIF + BASE;
    localparam int LOAD_BYTES = 5;
    localparam int BYTE_CYC   = 3;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_rst_n = 1'b0;
    logic [SW-1:0] strap_in = 8'h3C;
    logic ldr_done = 1'b0;
    logic bus_req = 1'b0;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic dom_rst_n, ldr_start, ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chip_reset_gate #(
        .SIF_CYCLES(SIF), .BASE_CYCLES(BASE), .STRAP_W(SW), .ADDR_W(AW)
    ) dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .strap_in(strap_in),
        .ldr_done(ldr_done), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dom_rst_n(dom_rst_n),
        .ldr_start(ldr_start), .ready(ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    // fields: we(1) addr(4) wdata(32) exp_data(32) exp_err(1) req(4)
    localparam int NV = 11;
    localparam logic [73:0] VEC [NV] = '{
        {1'b1, 4'd3, 32'hA5A5A5A5, 32'h0,        1'b0, 4'd10}, // R10 scratch write
        {1'b0, 4'd3, 32'h0,        32'hA5A5A5A5, 1'b0, 4'd10}, // R10 scratch read
        {1'b0, 4'd0, 32'h0,        32'h87654321, 1'b0, 4'd4},  // R4
        {1'b0, 4'd1, 32'h0,        32'h00005A01, 1'b0, 4'd3},  // R3
        {1'b1, 4'd0, 32'h0,        32'h0,        1'b0, 4'd11}, // R11
        {1'b0, 4'd0, 32'h0,        32'h87654321, 1'b0, 4'd11}, // R11
        {1'b0, 4'd2, 32'h0,        32'h0,        1'b0, 4'd9},  // R9
        {1'b0, 4'd7, 32'h0,        32'h0,        1'b1, 4'd10}, // R10
        {1'b1, 4'd9, 32'hFFFF,     32'h0,        1'b1, 4'd10}, // R10
        {1'b1, 4'd1, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd11}, // R11
        {1'b0, 4'd1, 32'h0,        32'h00005A01, 1'b0, 4'd11}  // R11
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit we, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output bit er, output bit vl);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(posedge clk); @(negedge clk);
        rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic count_start(output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
        end while (!ldr_start && n < 500);
    endtask

    task automatic run_loader(input string req);
        repeat (LOAD_BYTES * BYTE_CYC) @(negedge clk);
        chk(ready == 1'b0, req, {31'd0, ready}, 32'd0);
        ldr_done = 1'b1;
        @(negedge clk);
        ldr_done = 1'b0;
        chk(ready == 1'b1, req, {31'd0, ready}, 32'd1);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit e, v;
        int n;

        #20; @(negedge clk);
        // R1: reset state under power-on
        chk(!dom_rst_n && !ready && !ldr_start, "R1",
            {29'd0, dom_rst_n, ready, ldr_start}, 32'd0);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!dom_rst_n && !ready, "R1", {30'd0, dom_rst_n, ready}, 32'd0);

        bus_op(1'b0, 4'd0, 32'd0, d, e, v);
        chk(d == 32'hFFFFFFFF && !e, "R4", d, 32'hFFFFFFFF);
        chk(v == 1'b1, "R8", {31'd0, v}, 32'd1);
        bus_op(1'b0, 4'd1, 32'd0, d, e, v);
        chk(d == 32'h00003C00 && !e, "R3", d, 32'h00003C00);
        bus_op(1'b0, 4'd3, 32'd0, d, e, v);
        chk(d == 32'd0 && e, "R6", {d[30:0], e}, 32'd1);
        bus_op(1'b1, 4'd3, 32'h1234, d, e, v);
        chk(e == 1'b1, "R7", {31'd0, e}, 32'd1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", {31'd0, rsp_valid}, 32'd0);

        // R2: release the pin, time the loader start
        strap_in = 8'h5A;
        ext_rst_n = 1'b1;
        count_start(n);
        chk(n == PIN_TO_START, "R2", n, PIN_TO_START);
        @(negedge clk);
        chk(ldr_start == 1'b0, "R2", {31'd0, ldr_start}, 32'd0);

        bus_op(1'b0, 4'd0, 32'd0, d, e, v);
        chk(d == 32'h87654321 && !e, "R4", d, 32'h87654321);
        bus_op(1'b0, 4'd1, 32'd0, d, e, v);
        chk(d == 32'h00005A00, "R3", d, 32'h00005A00);
        bus_op(1'b1, 4'd3, 32'hDEAD, d, e, v);
        chk(e == 1'b1, "R7", {31'd0, e}, 32'd1);
        bus_op(1'b0, 4'd2, 32'd0, d, e, v);
        chk(!e, "R6", {31'd0, e}, 32'd0);
        run_loader("R5");
        bus_op(1'b0, 4'd3, 32'd0, d, e, v);
        chk(d == 32'd0 && !e, "R7", d, 32'd0);

        // table of accesses while ready
        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i][73], VEC[i][72:69], VEC[i][68:37], d, e, v);
            chk(d == VEC[i][36:5] && e == VEC[i][4] && v,
                $sformatf("R%0d", VEC[i][3:0]), d, VEC[i][36:5]);
        end

        // R1: pin reset from the running state
        ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dom_rst_n && !ready, "R1", {30'd0, dom_rst_n, ready}, 32'd0);
        ext_rst_n = 1'b1;
        repeat (SIF + 5) @(negedge clk);
        chk(ldr_start == 1'b0 && dom_rst_n, "R1", {31'd0, dom_rst_n}, 32'd1);
        // restart in the middle of the base delay
        strap_in = 8'h81;
        ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_rst_n = 1'b1;
        count_start(n);
        chk(n == PIN_TO_START, "R1", n, PIN_TO_START);
        run_loader("R5");
        bus_op(1'b0, 4'd3, 32'd0, d, e, v);
        chk(d == 32'd0 && !e, "R10", d, 32'd0);
        bus_op(1'b0, 4'd1, 32'd0, d, e, v);
        chk(d == 32'h00008101, "R3", d, 32'h00008101);

        // R9: software restart, with a stray done pulse (R5)
        bus_op(1'b1, 4'd2, 32'd1, d, e, v);
        chk(!e && ready == 1'b0, "R9", {30'd0, e, ready}, 32'd0);
        n = 0;
        do begin
            ldr_done = (n == 5);
            @(posedge clk); @(negedge clk);
            n++;
            if (ready) chk(1'b0, "R5", 32'd1, 32'd0);
        end while (!ldr_start && n < 500);
        ldr_done = 1'b0;
        chk(n == SOFT_TO_START, "R9", n, SOFT_TO_START);
        run_loader("R5");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule